// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software programs over a small 16-bit register bus made of an address, a write strobe, a read strobe and write and read data. A prescaler divides the clock into count ticks. A down-counter loaded from a programmable period moves one step per tick. When it runs out the first time, the block raises a warning flag and reloads itself. If it runs out again before software has cleared that flag, the block raises a second flag and issues a one-cycle reset request. A no-reboot bit can mask that request.

Software keeps the system alive by writing to the restart register before the count runs out. It can also read the remaining count, freeze the counter with a halt bit, and clear either flag by writing a one to it. The reset logic that acts on the request is outside this block. Out of reset the timer is halted and masked, so nothing happens until software has set it up.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, control (0x08) reads 0x0801 (halt and no-reboot set), the period register (0x12) reads 50, both status registers read 0, the count reads 50 and stays there while halted, and rst_req is low.
- R2: All 16 bits written to the period register (0x12) read back unchanged. Only bits 9:0 set the period.
- R3: A write of any value to 0x00 loads the count with the effective period and restarts the tick phase. A read of 0x00 returns the count in bits 9:0 with bits 15:10 zero. Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.
- R4: The count falls by one on each tick, and a tick comes every TICK_DIV clocks after a restart. The tick that finds the count at 0 is the expiry, so expiry falls (period+1)*TICK_DIV clocks after a restart. At expiry the count reloads with the period.
- R5: Control bit 11 is the halt bit. While it is set, both the count and the tick phase freeze. Clearing it resumes counting from the frozen phase. The bit reads back as written.
- R6: An expiry while status-1 (0x04) bit 3 is clear sets that bit and does not request a reset. Writing 1 to bit 3 clears it, and writing 0 leaves it unchanged.
- R7: An expiry while status-1 bit 3 is set also sets status-2 (0x06) bit 1, which is cleared by writing 1 to it. The same expiry drives rst_req high for exactly the one cycle after the expiring clock edge.
- R8: When control bit 0 (no-reboot) is set, rst_req stays low, but both status flags still update as in R6 and R7.
- R9: After a second-stage expiry the counter reloads and keeps running. Each later expiry with status-1 bit 3 still set pulses rst_req again.
- R10: A period field below 4 counts as 4. The register still reads back the value written.
- R11: Writes to unmapped addresses have no effect, and reads of them return 0. Control bits other than 11 and 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after bus_rd |
| rst_req | output | 1 | One-cycle reset request from the second stage |

## Verification
Read data is due one clock after its strobe. The count changes exactly TICK_DIV clocks apart, counted from the restart write. Flags and the reset pulse become visible in the cycle after the expiring edge, which falls (period+1)*TICK_DIV clocks after the restart. The bench numbers every clock edge and schedules each read on a known edge relative to the restart write. Its monitor compares each read one cycle after the strobe and records the edge on which each reset pulse is seen. It probes on both sides of each expiry and of each tick after halt is released, which pins down the exact edge rather than just the eventual value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 16;

  localparam logic [BUS_AW-1:0] ADR_RESTART = 8'h00;
  localparam logic [BUS_AW-1:0] ADR_FLAG1   = 8'h04;
  localparam logic [BUS_AW-1:0] ADR_FLAG2   = 8'h06;
  localparam logic [BUS_AW-1:0] ADR_CTRL    = 8'h08;
  localparam logic [BUS_AW-1:0] ADR_PERIOD  = 8'h12;

  localparam int CTRL_HALT_BIT = 11;
  localparam int CTRL_NOREBOOT_BIT = 0;
  localparam int FLAG1_BIT = 3;
  localparam int FLAG2_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RESTART, SEL_FLAG1, SEL_FLAG2, SEL_CTRL, SEL_PERIOD
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
    case (a)
      ADR_RESTART: return SEL_RESTART;
      ADR_FLAG1:   return SEL_FLAG1;
      ADR_FLAG2:   return SEL_FLAG2;
      ADR_CTRL:    return SEL_CTRL;
      ADR_PERIOD:  return SEL_PERIOD;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    tick    = 1'b0;
    if (restart) begin
      phase_d = '0;
    end else if (run) begin
      if (phase_q == LAST) begin
        phase_d = '0;
        tick    = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R5: a halted prescaler keeps its phase
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 10,
  parameter int MIN_PERIOD = 4,
  parameter int DEF_PERIOD = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] MINV = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] DEFV = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] cnt_q, cnt_d, eff;

  always_comb begin
    eff    = (period < MINV) ? MINV : period;
    expire = tick && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (restart)     cnt_d = eff;
    else if (expire) cnt_d = eff;
    else if (tick)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= DEFV;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: a restart loads the effective period
  p_restart_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(eff)));
  // R4: an expiry reloads rather than wrapping
  p_expire_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !restart) |=> (cnt_q == $past(eff)));
  // R10: the loaded count is never below the floor
  p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q >= MINV));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DEF_PERIOD = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              halt,
  output logic              noreboot,
  output logic [CNT_W-1:0]  period,
  output logic              restart,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              rst_req
);
  reg_sel_e sel;
  logic halt_q, halt_d, nr_q, nr_d;
  logic flag1_q, flag1_d, flag2_q, flag2_d;
  logic req_q, req_d;
  logic [BUS_DW-1:0] per_q, per_d, rdata_q, rdata_d;
  logic clr1, clr2, wr_ctrl, wr_per;

  always_comb begin
    sel     = decode_addr(bus_addr);
    restart = bus_wr && (sel == SEL_RESTART);
    wr_ctrl = bus_wr && (sel == SEL_CTRL);
    wr_per  = bus_wr && (sel == SEL_PERIOD);
    clr1    = bus_wr && (sel == SEL_FLAG1) && bus_wdata[FLAG1_BIT];
    clr2    = bus_wr && (sel == SEL_FLAG2) && bus_wdata[FLAG2_BIT];

    halt_d  = wr_ctrl ? bus_wdata[CTRL_HALT_BIT] : halt_q;
    nr_d    = wr_ctrl ? bus_wdata[CTRL_NOREBOOT_BIT] : nr_q;
    per_d   = wr_per ? bus_wdata : per_q;

    flag1_d = expire | (flag1_q & ~clr1);
    flag2_d = (expire & flag1_q) | (flag2_q & ~clr2);
    req_d   = expire & flag1_q & ~nr_q;

    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      case (sel)
        SEL_RESTART: rdata_d[CNT_W-1:0] = count;
        SEL_FLAG1:   rdata_d[FLAG1_BIT] = flag1_q;
        SEL_FLAG2:   rdata_d[FLAG2_BIT] = flag2_q;
        SEL_CTRL: begin
          rdata_d[CTRL_HALT_BIT]     = halt_q;
          rdata_d[CTRL_NOREBOOT_BIT] = nr_q;
        end
        SEL_PERIOD:  rdata_d = per_q;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b1;
      nr_q    <= 1'b1;
      per_q   <= BUS_DW'(DEF_PERIOD);
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
      req_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      halt_q  <= halt_d;
      nr_q    <= nr_d;
      per_q   <= per_d;
      flag1_q <= flag1_d;
      flag2_q <= flag2_d;
      req_q   <= req_d;
      rdata_q <= rdata_d;
    end
  end

  assign halt      = halt_q;
  assign noreboot  = nr_q;
  assign period    = per_q[CNT_W-1:0];
  assign bus_rdata = rdata_q;
  assign rst_req   = req_q;

  // R7: the second flag only rises on top of the first
  p_stage_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag2_q) |-> $past(flag1_q));
  // R7: a reset request always comes with the second flag
  p_req_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> flag2_q);
  // R8: a masked cycle never produces a request
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nr_q) |-> !req_q);
  // R9: each request lasts one cycle
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int CNT_W = 10,
  parameter int MIN_PERIOD = 4,
  parameter int DEF_PERIOD = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req
);
  logic [1:0] sync_q;
  logic rst_int_n;
  logic halt, noreboot, restart, tick, expire;
  logic [CNT_W-1:0] period, count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  wdog_regs #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .count(count), .expire(expire),
    .halt(halt), .noreboot(noreboot), .period(period), .restart(restart),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  wdog_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run(!halt), .restart(restart), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .restart(restart),
    .period(period), .count(count), .expire(expire)
  );

  // R5: the count holds while halted unless restarted
  p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halt && !restart) |=> $stable(count));
  // R8: the mask bit observed at the port suppresses the request
  p_masked_port_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(noreboot) |-> !rst_req);
endmodule

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
  localparam int DIV = 4;
  localparam logic [7:0] A_RST = 8'h00, A_F1 = 8'h04, A_F2 = 8'h06,
                         A_CT = 8'h08, A_PER = 8'h12, A_BAD = 8'h0A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic rst_req;

  int n_chk = 0, n_bad = 0, cyc = 0, pulses = 0, last_pulse = -1;
  int r0;
  logic rd_pend = 1'b0;
  logic done = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  wdog_two_stage #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_pend <= bus_rd;
  end

  // monitor: compares each read one cycle after its strobe, records pulses
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read 0x%04h expected 0x%04h", t, bus_rdata, e);
      end
    end
    if (rst_req === 1'b1) begin
      pulses++;
      last_pulse = cyc;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string t, input int act, input int e);
    n_chk++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", t, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd(A_CT, 16'h0801, "R1 control");
    rd(A_PER, 16'd50, "R1 period");
    rd(A_F1, 16'h0000, "R1 flag1");
    rd(A_F2, 16'h0000, "R1 flag2");
    idle(20);
    rd(A_RST, 16'd50, "R1 count held while halted");
    chk("R1 no request", pulses, 0);

    // R2 period readback with upper bits
    wr(A_CT, 16'h0001);
    wr(A_PER, 16'hA804);
    rd(A_PER, 16'hA804, "R2 period readback");
    wr(A_RST, 16'h1234);
    r0 = cyc;
    rd(A_RST, 16'd4, "R3 count after restart");           // r0+1
    idle(6);
    rd(A_RST, 16'd3, "R4 count after one tick");          // r0+8
    idle(11);
    rd(A_F1, 16'h0000, "R4 no expiry before edge");       // r0+20
    rd(A_F1, 16'h0008, "R6 first expiry flag");           // r0+21
    rd(A_F2, 16'h0000, "R6 no second flag");              // r0+22
    rd(A_RST, 16'd4, "R4 reload at expiry");              // r0+23
    idle(21);
    rd(A_F2, 16'h0002, "R8 second flag while masked");    // r0+45
    chk("R8 request masked", pulses, 0);
    rd(A_CT, 16'h0001, "R5 control readback");            // r0+46
    wr(A_F1, 16'h0000);                                   // r0+47
    rd(A_F1, 16'h0008, "R6 write zero keeps flag");       // r0+48
    wr(A_F1, 16'h0008);
    wr(A_F2, 16'h0002);
    rd(A_F1, 16'h0000, "R6 flag1 cleared");
    rd(A_F2, 16'h0000, "R7 flag2 cleared");
    wr(A_CT, 16'h0000);                                   // r0+53

    // R7 / R9 second stage with request enabled
    wr(A_RST, 16'h0000);
    r0 = cyc;
    idle(43);
    chk("R7 one pulse", pulses, 1);
    chk("R7 pulse edge", last_pulse, r0 + 40);
    rd(A_F2, 16'h0002, "R7 flag2 set");
    idle(19);
    chk("R9 second pulse", pulses, 2);
    chk("R9 pulse edge", last_pulse, r0 + 60);

    // R5 halt freezes count and phase
    wr(A_RST, 16'h0000);
    wr(A_CT, 16'h0800);
    rd(A_RST, 16'd4, "R5 frozen count a");
    idle(10);
    rd(A_RST, 16'd4, "R5 frozen count b");
    rd(A_CT, 16'h0800, "R5 halt readback");
    wr(A_CT, 16'h0000);
    rd(A_RST, 16'd4, "R5 resume u+1");
    idle(1);
    rd(A_RST, 16'd4, "R5 resume u+3");
    rd(A_RST, 16'd3, "R5 resume phase tick");

    // R10 floor
    wr(A_CT, 16'h0801);
    wr(A_PER, 16'h0002);
    rd(A_PER, 16'h0002, "R10 period readback");
    wr(A_RST, 16'h0000);
    rd(A_RST, 16'd4, "R10 floor count");

    // R11 unmapped
    wr(A_BAD, 16'hFFFF);
    rd(A_BAD, 16'h0000, "R11 unmapped read");
    rd(A_PER, 16'h0002, "R11 period untouched");
    wr(A_CT, 16'hFFFF);
    rd(A_CT, 16'h0801, "R11 spare control bits");
    idle(3);
    chk("R3 all reads returned", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule